// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block sequences single conversions of an external successive-approximation analog-to-digital converter. A 32-bit mode register holds the timing and trigger settings. The block divides the input clock down to a conversion clock and, once a conversion is requested, drives three mutually exclusive phase strobes to the converter: a power-up settling phase, a sample-and-hold window and a conversion window. A one-cycle done pulse marks the end of each conversion. The settling phase, the sampling window and the conversion window are each a programmed number of conversion-clock periods.

A conversion is requested either by a software start strobe or by a rising edge on one hardware trigger line. The hardware trigger is picked from six internal lines and one external line, and it is honoured only when the trigger enable bit is set. Trigger lines are asynchronous and pass through a two-flop synchronizer before edge detection. With the sleep bit set, the converter is powered down after every conversion and each new conversion pays the full settling delay. With the sleep bit clear, the converter stays powered after its first settling phase and later conversions go straight to sampling.

The analog converter, the result data path, channel selection and interrupts are outside this block. The converter is modelled as a fixed count of conversion-clock periods.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the mode register reads 0 and adcPowerOn, adcSample, adcConvert, adcLowRes and convDone are all 0.
- R2: A write stores the defined fields and reads them back. Reserved bits (31:28, 23, 7:6) always read 0. The field positions are: trigger enable bit 0, trigger select bits 3:1, low-resolution bit 4, sleep bit 5, prescaler bits 15:8, settling count bits 22:16, sample count bits 27:24.
- R3: With divisor D = (prescaler+1)*2 input clocks, a cold start keeps adcPowerOn high with no phase strobe for (settling+1)*8*D cycles. adcPowerOn rises in the first cycle after the start is accepted.
- R4: adcSample is high for exactly (sample+3)*D cycles and starts straight after the settling phase, or straight after the start when the converter is already powered.
- R5: adcConvert follows adcSample directly and lasts 10*D cycles when the low-resolution bit is 0, or 8*D cycles when it is 1. adcLowRes equals the low-resolution bit.
- R6: convDone is high for exactly one cycle, in the cycle right after adcConvert falls. At most one of the settling, sampling and conversion phases is active at any time.
- R7: With the sleep bit at 0, adcPowerOn stays high after a conversion, and the next conversion begins sampling with no settling phase.
- R8: With the sleep bit at 1, adcPowerOn is low in the convDone cycle, and every conversion begins with the full settling phase.
- R9: With the trigger enable bit at 0, edges on the hardware trigger lines start nothing. A software start still starts a conversion.
- R10: With the trigger enable bit at 1, trigger select 0..5 picks internal line 0..5, 6 picks the external line, and 7 picks no line. Only a rising edge of the selected line starts a conversion; holding the line high does not start another one.
- R11: A start request that arrives while a conversion is in progress is dropped. It does not start a further conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Mode register write strobe |
| cfgWdata | input | 32 | Mode register write data |
| cfgRdata | output | 32 | Mode register read data |
| swStart | input | 1 | Software conversion start, sampled each cycle |
| intTrig | input | 6 | Internal hardware trigger lines (asynchronous) |
| extTrig | input | 1 | External hardware trigger line (asynchronous) |
| adcPowerOn | output | 1 | Converter power-up control |
| adcSample | output | 1 | Sample-and-hold window strobe |
| adcConvert | output | 1 | Conversion window strobe |
| adcLowRes | output | 1 | Resolution select: 1 for 8-bit, 0 for 10-bit |
| convDone | output | 1 | One-cycle end-of-conversion pulse |

## Verification
Several properties are checked on every cycle:
- the done pulse is a single cycle and comes straight after the conversion phase;
- in sleep mode, power is off when done is raised;
- a powered converter goes straight to sampling;
- a start request during a running conversion leaves the phase unchanged;
- the phase counters are clear while idle.

Only the directed scenarios can show the following:
- the exact phase lengths for several prescaler, settling and sample values;
- the low- and high-resolution conversion lengths;
- the readback mask;
- which trigger line each select value picks;
- that a level held high starts only one conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int PRESC_W       = 8;
  localparam int STUP_W        = 7;
  localparam int SHT_W         = 4;
  localparam int TSEL_W        = 3;
  localparam int NUM_INT_TRIG  = 6;
  localparam int CONV_CYC_HI   = 10;
  localparam int CONV_CYC_LO   = 8;
  localparam int SHT_OFFSET    = 3;
  localparam int STUP_SHIFT    = 3;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETTLE  = 2'd1,
    PH_SAMPLE  = 2'd2,
    PH_CONVERT = 2'd3
  } phase_e;

  typedef struct packed {
    logic   clrCnt;
    phase_e phase;
  } dpCtl_t;
endpackage

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int NUM_SRC = NUM_INT_TRIG + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PRESC_W-1:0] prescal,
  input  logic [STUP_W-1:0]  settleCnt,
  input  logic [SHT_W-1:0]   sampleCnt,
  input  logic               lowRes,
  input  logic [TSEL_W-1:0]  trgSel,
  input  logic [NUM_SRC-1:0] trigLines,
  input  dpCtl_t             dpCtl,
  output logic               phaseEnd,
  output logic               hwEdge
);
  localparam int DIV_W = PRESC_W + 2;
  localparam int CNT_W = STUP_W + STUP_SHIFT + 1;

  logic [DIV_W-1:0] divisor, divCnt;
  logic [CNT_W-1:0] phaseCnt, target;
  logic             tick;

  assign divisor = (DIV_W'(prescal) + DIV_W'(1)) << 1;
  assign tick    = (divCnt >= divisor - DIV_W'(1));

  always_comb begin
    case (dpCtl.phase)
      PH_SETTLE:  target = (CNT_W'(settleCnt) + CNT_W'(1)) << STUP_SHIFT;
      PH_SAMPLE:  target = CNT_W'(sampleCnt) + CNT_W'(SHT_OFFSET);
      PH_CONVERT: target = lowRes ? CNT_W'(CONV_CYC_LO) : CNT_W'(CONV_CYC_HI);
      default:    target = CNT_W'(1);
    endcase
  end

  assign phaseEnd = (dpCtl.phase != PH_IDLE) && tick &&
                    (phaseCnt >= target - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      phaseCnt <= '0;
    end else if (dpCtl.clrCnt) begin
      divCnt   <= '0;
      phaseCnt <= '0;
    end else if (tick) begin
      divCnt   <= '0;
      phaseCnt <= phaseCnt + CNT_W'(1);
    end else begin
      divCnt   <= divCnt + DIV_W'(1);
    end
  end

  // Trigger synchronizers, one pair per source line
  logic [NUM_SRC-1:0] syncA, syncB;
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncA[i] <= 1'b0;
          syncB[i] <= 1'b0;
        end else begin
          syncA[i] <= trigLines[i];
          syncB[i] <= syncA[i];
        end
      end
    end
  endgenerate

  logic selLine, selPrev;
  assign selLine = (int'(trgSel) < NUM_SRC) ? syncB[trgSel] : 1'b0;
  assign hwEdge  = selLine & ~selPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selPrev <= 1'b0;
    else       selPrev <= selLine;
  end

  // R3: counters rest at zero while the sequencer is idle
  a_r3_idle_clear: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.phase == PH_IDLE) |-> (divCnt == '0 && phaseCnt == '0));
endmodule

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl
  import adc_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sleepMode,
  input  logic   trgEn,
  input  logic   swStart,
  input  logic   hwEdge,
  input  logic   phaseEnd,
  output dpCtl_t dpCtl,
  output logic   powerOn,
  output logic   sampleOn,
  output logic   convertOn,
  output logic   convDone
);
  phase_e state;
  logic   warm, doneQ, startReq;

  assign startReq     = swStart | (trgEn & hwEdge);
  assign dpCtl.phase  = state;
  assign dpCtl.clrCnt = (state == PH_IDLE) || phaseEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= PH_IDLE;
      warm  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        PH_IDLE:    if (startReq) state <= warm ? PH_SAMPLE : PH_SETTLE;
        PH_SETTLE:  if (phaseEnd) begin
                      state <= PH_SAMPLE;
                      warm  <= ~sleepMode;
                    end
        PH_SAMPLE:  if (phaseEnd) state <= PH_CONVERT;
        PH_CONVERT: if (phaseEnd) begin
                      state <= PH_IDLE;
                      doneQ <= 1'b1;
                      if (sleepMode) warm <= 1'b0;
                    end
        default:    state <= PH_IDLE;
      endcase
    end
  end

  assign powerOn   = (state != PH_IDLE) || warm;
  assign sampleOn  = (state == PH_SAMPLE);
  assign convertOn = (state == PH_CONVERT);
  assign convDone  = doneQ;

  // R6: done is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !convDone);
  // R6: done only directly after the conversion phase
  a_r6_done_after_conv: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> $past(state == PH_CONVERT));
  // R8: sleep mode powers down by the done cycle
  a_r8_sleep_off: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && $past(sleepMode)) |-> !powerOn);
  // R7: a powered converter skips the settling phase
  a_r7_warm_skip: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_IDLE && startReq && warm) |=> (state == PH_SAMPLE));
  // R11: requests while busy do not disturb the sequence
  a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (state != PH_IDLE && startReq && !phaseEnd) |=> $stable(state));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWe,
  input  logic [31:0]             cfgWdata,
  output logic [31:0]             cfgRdata,
  input  logic                    swStart,
  input  logic [NUM_INT_TRIG-1:0] intTrig,
  input  logic                    extTrig,
  output logic                    adcPowerOn,
  output logic                    adcSample,
  output logic                    adcConvert,
  output logic                    adcLowRes,
  output logic                    convDone
);
  localparam logic [31:0] FIELD_MASK = 32'h0F7F_FF3F;
  localparam int BIT_TEN  = 0;
  localparam int BIT_TSEL = 1;
  localparam int BIT_LRES = 4;
  localparam int BIT_SLP  = 5;
  localparam int BIT_PRE  = 8;
  localparam int BIT_STUP = 16;
  localparam int BIT_SHT  = 24;

  logic [31:0] modeQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      modeQ <= '0;
    else if (cfgWe) modeQ <= cfgWdata & FIELD_MASK;
  end
  assign cfgRdata = modeQ;

  dpCtl_t dpCtl;
  logic   phaseEnd, hwEdge;

  adc_seq_dp #(.NUM_SRC(NUM_INT_TRIG + 1)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .prescal   (modeQ[BIT_PRE +: PRESC_W]),
    .settleCnt (modeQ[BIT_STUP +: STUP_W]),
    .sampleCnt (modeQ[BIT_SHT +: SHT_W]),
    .lowRes    (modeQ[BIT_LRES]),
    .trgSel    (modeQ[BIT_TSEL +: TSEL_W]),
    .trigLines ({extTrig, intTrig}),
    .dpCtl     (dpCtl),
    .phaseEnd  (phaseEnd),
    .hwEdge    (hwEdge)
  );

  adc_seq_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .sleepMode (modeQ[BIT_SLP]),
    .trgEn     (modeQ[BIT_TEN]),
    .swStart   (swStart),
    .hwEdge    (hwEdge),
    .phaseEnd  (phaseEnd),
    .dpCtl     (dpCtl),
    .powerOn   (adcPowerOn),
    .sampleOn  (adcSample),
    .convertOn (adcConvert),
    .convDone  (convDone)
  );

  assign adcLowRes = modeQ[BIT_LRES];
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        swStart = 1'b0;
  logic [5:0]  intTrig = '0;
  logic        extTrig = 1'b0;
  logic        adcPowerOn, adcSample, adcConvert, adcLowRes, convDone;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  adc_seq_ctrl dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .swStart(swStart), .intTrig(intTrig), .extTrig(extTrig),
    .adcPowerOn(adcPowerOn), .adcSample(adcSample), .adcConvert(adcConvert),
    .adcLowRes(adcLowRes), .convDone(convDone)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeMode(input int pre, input int stup, input int sht, input bit slp,
                           input bit lres, input int tsel, input bit ten);
    @(negedge clk);
    cfgWdata = (32'(sht) << 24) | (32'(stup) << 16) | (32'(pre) << 8) |
               (32'(slp) << 5) | (32'(lres) << 4) | (32'(tsel) << 1) | 32'(ten);
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Software start, then count the negedges spent in each phase
  task automatic runSw(input bit poke, output int nSt, output int nSh, output int nCv,
                       output bit doneOne, output bit pwrAfter);
    nSt = 0; nSh = 0; nCv = 0;
    @(negedge clk) swStart = 1'b1;
    @(negedge clk);
    for (int g = 0; g < 20000; g++) begin
      swStart = 1'b0;
      if (convDone) break;
      if (adcSample) begin
        nSh++;
        if (poke && nSh == 2) swStart = 1'b1;
      end else if (adcConvert) begin
        nCv++;
        if (poke && nCv == 3) swStart = 1'b1;
      end else if (adcPowerOn) nSt++;
      @(negedge clk);
    end
    pwrAfter = adcPowerOn;
    @(negedge clk);
    doneOne = !convDone;
  endtask

  // Watch for a conversion for up to lim cycles; waits for its done pulse
  task automatic watchConv(input int lim, output bit seen);
    seen = 1'b0;
    for (int g = 0; g < lim; g++) begin
      @(negedge clk);
      if (adcSample || adcConvert || convDone) seen = 1'b1;
      if (convDone) break;
    end
    if (seen) begin
      for (int g = 0; g < 2000 && !convDone; g++) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic testReset;
    chk(cfgRdata == 0, "R1 mode reg", cfgRdata, 0);
    chk({adcPowerOn, adcSample, adcConvert, adcLowRes, convDone} == 0,
        "R1 outputs", {adcPowerOn, adcSample, adcConvert, adcLowRes, convDone}, 0);
  endtask

  task automatic testReadback;
    @(negedge clk);
    cfgWdata = 32'hFFFF_FFFF; cfgWe = 1'b1;
    @(negedge clk); cfgWe = 1'b0;
    chk(cfgRdata == 32'h0F7F_FF3F, "R2 mask", cfgRdata, 32'h0F7F_FF3F);
    chk(adcLowRes == 1'b1, "R5 lowres pin", adcLowRes, 1);
    writeMode(5, 33, 9, 0, 0, 4, 1);
    chk(cfgRdata == 32'h0921_0509, "R2 fields", cfgRdata, 32'h0921_0509);
  endtask

  task automatic testSleepTiming(input int pre, input int stup, input int sht, input bit lres);
    int nSt, nSh, nCv, d;
    bit one, pwr;
    d = (pre + 1) * 2;
    writeMode(pre, stup, sht, 1, lres, 7, 0);
    runSw(0, nSt, nSh, nCv, one, pwr);
    chk(nSt == (stup + 1) * 8 * d, "R3 settle len", nSt, (stup + 1) * 8 * d);
    chk(nSh == (sht + 3) * d, "R4 sample len", nSh, (sht + 3) * d);
    chk(nCv == (lres ? 8 : 10) * d, "R5 convert len", nCv, (lres ? 8 : 10) * d);
    chk(one, "R6 done width", one, 1);
    chk(!pwr, "R8 power off at done", pwr, 0);
  endtask

  task automatic testNormal;
    int nSt, nSh, nCv;
    bit one, pwr;
    writeMode(0, 0, 0, 0, 0, 7, 0);
    runSw(0, nSt, nSh, nCv, one, pwr);
    chk(nSt == 16, "R8 cold settle after sleep", nSt, 16);
    chk(pwr, "R7 power stays on", pwr, 1);
    repeat (5) @(negedge clk);
    chk(adcPowerOn, "R7 power idle", adcPowerOn, 1);
    runSw(0, nSt, nSh, nCv, one, pwr);
    chk(nSt == 0, "R7 no settle when warm", nSt, 0);
    chk(nSh == 6, "R4 sample len warm", nSh, 6);
    chk(nCv == 20, "R5 convert len", nCv, 20);
  endtask

  task automatic testBusyIgnore;
    int nSt, nSh, nCv;
    bit one, pwr, seen;
    runSw(1, nSt, nSh, nCv, one, pwr);
    chk(nSh == 6 && nCv == 20, "R11 sequence intact", nSh * 100 + nCv, 620);
    watchConv(80, seen);
    chk(!seen, "R11 busy start dropped", seen, 0);
  endtask

  task automatic pulseInt(input int idx);
    @(negedge clk) intTrig[idx] = 1'b1;
    repeat (4) @(negedge clk);
    intTrig[idx] = 1'b0;
  endtask

  task automatic testTrigDisabled;
    int nSt, nSh, nCv;
    bit one, pwr, seen;
    writeMode(0, 0, 0, 0, 0, 0, 0);
    pulseInt(0);
    watchConv(100, seen);
    chk(!seen, "R9 hw ignored when disabled", seen, 0);
    runSw(0, nSt, nSh, nCv, one, pwr);
    chk(nSh == 6, "R9 sw start works", nSh, 6);
  endtask

  task automatic testTrigSelect;
    bit seen;
    writeMode(0, 0, 0, 0, 0, 2, 1);
    pulseInt(3);
    watchConv(100, seen);
    chk(!seen, "R10 unselected line", seen, 0);
    pulseInt(2);
    watchConv(100, seen);
    chk(seen, "R10 internal line 2", seen, 1);
    writeMode(0, 0, 0, 0, 0, 5, 1);
    pulseInt(5);
    watchConv(100, seen);
    chk(seen, "R10 internal line 5", seen, 1);
    writeMode(0, 0, 0, 0, 0, 6, 1);
    @(negedge clk) extTrig = 1'b1;
    repeat (4) @(negedge clk);
    extTrig = 1'b0;
    watchConv(100, seen);
    chk(seen, "R10 external line", seen, 1);
    writeMode(0, 0, 0, 0, 0, 7, 1);
    @(negedge clk) begin intTrig = 6'h3F; extTrig = 1'b1; end
    repeat (4) @(negedge clk);
    intTrig = '0; extTrig = 1'b0;
    watchConv(100, seen);
    chk(!seen, "R10 select 7 none", seen, 0);
    writeMode(0, 0, 0, 0, 0, 1, 1);
    @(negedge clk) intTrig[1] = 1'b1;
    watchConv(100, seen);
    chk(seen, "R10 level first edge", seen, 1);
    watchConv(150, seen);
    chk(!seen, "R10 held level no retrigger", seen, 0);
    intTrig[1] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testReadback();
    testSleepTiming(1, 2, 1, 0);
    testSleepTiming(0, 0, 0, 1);
    testSleepTiming(3, 1, 15, 0);
    testNormal();
    testBusyIgnore();
    testTrigDisabled();
    testTrigSelect();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule